// File: doc/BRIEF.md
# Single-cycle 32-bit integer processor core

This block is a 32-bit processor core that finishes every instruction in one clock. It runs a small integer subset:

- register-to-register add, subtract, AND, OR and signed set-less-than;
- add-immediate, load word and store word;
- branch-if-equal and branch-if-not-equal;
- an absolute jump.

The core holds the program counter, a 32-entry register file, the immediate extender, the next-PC logic, one merged decoder and the ALU. The merged decoder turns opcode and function fields into all datapath controls, including a 5-bit ALU function code.

Instruction memory and data memory sit outside the core, and both are read combinationally. The core presents `fetch_pc` and expects the instruction word back on `fetch_word` in the same cycle. A load gets its data back on `dmem_rdata` in the same cycle. A store asserts `dmem_we` for one cycle, and the memory writes on the next rising edge. No port is a stream and there is no back-pressure: every memory must answer within the cycle.

Instruction fields are laid out as follows:

| Field | Bits |
|---|---|
| opcode | [31:26] |
| rs | [25:21] |
| rt | [20:16] |
| rd | [15:11] |
| function code | [5:0] |
| 16-bit immediate | [15:0] |
| 26-bit jump index | [25:0] |

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `dmem_we` is 0. On the first rising edge with `rst` high, `fetch_pc` becomes 0.
- R2: An instruction that is neither a taken branch nor a jump advances `fetch_pc` by 4 on the next rising edge.
- R3: Opcode 000000 selects a register operation by function code:
  - 100000: rd = rs + rt
  - 100010: rd = rs - rt
  - 100100: rd = rs AND rt
  - 100101: rd = rs OR rt
  - 101010: rd = 1 if rs < rt as signed numbers, otherwise 0
- R4: Opcode 001000 writes rs plus the sign-extended immediate into rt.
- R5: Opcode 100011 drives `dmem_addr` = rs + sign-extended immediate and writes `dmem_rdata` into rt.
- R6: Opcode 101011 asserts `dmem_we`, with `dmem_addr` = rs + sign-extended immediate and `dmem_wdata` = rt. It does not write any register.
- R7: Opcode 000100 (equal) and opcode 000101 (not equal) compare rs with rt. When the condition holds, the next PC is PC + 4 + (sign-extended immediate shifted left by 2). Otherwise it is PC + 4.
- R8: Opcode 000010 sets the next PC to {(PC+4)[31:28], jump index, 2'b00}.
- R9: Register 0 always reads as 0. Any write that targets it is discarded.
- R10: An unlisted opcode, or opcode 000000 with an unlisted function code, is a no-op: no register write, `dmem_we` = 0, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | 32 | Byte address of the current instruction |
| fetch_word | input | 32 | Instruction word at `fetch_pc`, returned in the same cycle |
| dmem_we | output | 1 | Store strobe for this cycle |
| dmem_addr | output | 32 | Byte address for loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, returned in the same cycle |

## Verification
The assertions assume that `fetch_word` and `dmem_rdata` always carry known values that have settled before the rising edge. This holds because both memories are combinational and have no wait state. The bench satisfies these assumptions by fully initialising its instruction and data arrays and by answering both ports combinationally. It drives `rst` only at falling edges. Every program the bench runs keeps its data addresses inside a 256-byte window, so every load returns a defined word.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int OPC_W = 6;
  localparam int ALUFN_W = 5;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_LD   = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_ST   = 6'b101011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  // ALU code layout: [4] invert-and-carry (subtract), [3:2] result class
  // (00 sum, 01 logic, 10 compare), [1:0] sub-operation within the class.
  localparam logic [ALUFN_W-1:0] ALU_ADD = 5'b00000;
  localparam logic [ALUFN_W-1:0] ALU_SUB = 5'b10000;
  localparam logic [ALUFN_W-1:0] ALU_AND = 5'b00100;
  localparam logic [ALUFN_W-1:0] ALU_OR  = 5'b00101;
  localparam logic [ALUFN_W-1:0] ALU_SLT = 5'b11000;

  typedef struct packed {
    logic                known;
    logic                reg_we;
    logic                dst_rd;
    logic                use_imm;
    logic                ext_signed;
    logic                mem_we;
    logic                mem_to_reg;
    logic                branch;
    logic                branch_ne;
    logic                jump;
    logic [ALUFN_W-1:0]  alu_fn;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [5:0]       funct,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.ext_signed = 1'b1;
    ctrl.alu_fn     = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        ctrl.known  = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.dst_rd = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_fn = ALU_ADD;
          FN_SUB:  ctrl.alu_fn = ALU_SUB;
          FN_AND:  ctrl.alu_fn = ALU_AND;
          FN_OR:   ctrl.alu_fn = ALU_OR;
          FN_SLT:  ctrl.alu_fn = ALU_SLT;
          default: begin
            ctrl.known  = 1'b0;
            ctrl.reg_we = 1'b0;
          end
        endcase
      end
      OPC_ADDI: begin
        ctrl.known   = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OPC_LD: begin
        ctrl.known      = 1'b1;
        ctrl.reg_we     = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OPC_ST: begin
        ctrl.known   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.known  = 1'b1;
        ctrl.branch = 1'b1;
        ctrl.alu_fn = ALU_SUB;
      end
      OPC_BNE: begin
        ctrl.known     = 1'b1;
        ctrl.branch    = 1'b1;
        ctrl.branch_ne = 1'b1;
        ctrl.alu_fn    = ALU_SUB;
      end
      OPC_JMP: begin
        ctrl.known = 1'b1;
        ctrl.jump  = 1'b1;
      end
      default: ctrl.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  ra_d,
  input  logic [AW-1:0] rb_a,
  output logic [W-1:0]  rb_d,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          regs[g] <= '0;
        else if (we && wa == AW'(g))
          regs[g] <= wd;
      end
    end
  end

  assign ra_d = regs[ra_a];
  assign rb_d = regs[rb_a];

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (rst)
    (ra_a == '0) |-> (ra_d == '0)); // R9
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst)
    (rb_a == '0) |-> (rb_d == '0)); // R9

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  logic [ALUFN_W-1:0] fn,
  output logic [W-1:0]       y,
  output logic               zero
);

  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         lt;

  assign b_eff = fn[4] ? ~b : b;
  assign sum   = a + b_eff + {{(W-1){1'b0}}, fn[4]};
  assign lt    = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];

  always_comb begin
    case (fn[3:2])
      2'b00: y = sum;
      2'b01: begin
        case (fn[1:0])
          2'b00:   y = a & b;
          2'b01:   y = a | b;
          default: y = '0;
        endcase
      end
      2'b10:   y = {{(W-1){1'b0}}, lt};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

  always_comb begin
    if (fn == ALU_SLT)
      AST_SLT_ONE_BIT: assert (y[W-1:1] == '0); // R3
  end

endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc #(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int JIX_W = 26
) (
  input  logic [W-1:0]     pc,
  input  logic [IMM_W-1:0] imm,
  input  logic [JIX_W-1:0] jidx,
  input  logic             take_br,
  input  logic             jump,
  output logic [W-1:0]     pc_next
);

  localparam int HI_W = W - JIX_W - 2;

  logic [W-1:0] pc_plus4;
  logic [W-1:0] br_off;
  logic [W-1:0] br_tgt;
  logic [W-1:0] j_tgt;

  assign pc_plus4 = pc + W'(4);
  assign br_off   = {{(W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  assign br_tgt   = pc_plus4 + br_off;
  assign j_tgt    = {pc_plus4[W-1 -: HI_W], jidx, 2'b00};

  always_comb begin
    if (jump)
      pc_next = j_tgt;
    else if (take_br)
      pc_next = br_tgt;
    else
      pc_next = pc_plus4;
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] fetch_pc,
  input  logic [31:0]     fetch_word,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int AW    = $clog2(NREG);
  localparam int IMM_W = 16;
  localparam int JIX_W = 26;

  logic [OPC_W-1:0] opcode;
  logic [5:0]       funct;
  logic [AW-1:0]    rs, rt, rd;
  logic [IMM_W-1:0] imm;
  logic [JIX_W-1:0] jidx;

  assign opcode = fetch_word[31:26];
  assign rs     = fetch_word[21 +: AW];
  assign rt     = fetch_word[16 +: AW];
  assign rd     = fetch_word[11 +: AW];
  assign funct  = fetch_word[5:0];
  assign imm    = fetch_word[IMM_W-1:0];
  assign jidx   = fetch_word[JIX_W-1:0];

  ctrl_t ctrl;

  sc_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  logic [XLEN-1:0] rs_val, rt_val, wb_val, imm_ext, alu_b, alu_y, pc_next;
  logic [AW-1:0]   wr_addr;
  logic            reg_we, alu_zero, take_br;
  logic [XLEN-1:0] pc_q;

  assign imm_ext = ctrl.ext_signed ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm}
                                   : {{(XLEN-IMM_W){1'b0}}, imm};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;
  assign wr_addr = ctrl.dst_rd ? rd : rt;
  assign wb_val  = ctrl.mem_to_reg ? dmem_rdata : alu_y;
  assign reg_we  = ctrl.reg_we & ~rst;

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (rs),
    .ra_d (rs_val),
    .rb_a (rt),
    .rb_d (rt_val),
    .we   (reg_we),
    .wa   (wr_addr),
    .wd   (wb_val)
  );

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (ctrl.alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign take_br = ctrl.branch & (alu_zero ^ ctrl.branch_ne);

  sc_nextpc #(.W(XLEN), .IMM_W(IMM_W), .JIX_W(JIX_W)) u_npc (
    .pc      (pc_q),
    .imm     (imm),
    .jidx    (jidx),
    .take_br (take_br),
    .jump    (ctrl.jump),
    .pc_next (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= RESET_PC[XLEN-1:0];
    else
      pc_q <= pc_next;
  end

  assign fetch_pc   = pc_q;
  assign dmem_we    = ctrl.mem_we & ~rst;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!take_br && !ctrl.jump) |=> (pc_q == $past(pc_q) + XLEN'(4))); // R2
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !reg_we); // R6
  AST_BRANCH_TGT: assert property (@(posedge clk) disable iff (rst)
    take_br |=> (pc_q == $past(pc_q) + XLEN'(4)
                 + {{(XLEN-IMM_W-2){$past(fetch_word[IMM_W-1])}},
                    $past(fetch_word[IMM_W-1:0]), 2'b00})); // R7
  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc_q[JIX_W+1:0] == {$past(fetch_word[JIX_W-1:0]), 2'b00})); // R8
  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl.known |-> (!reg_we && !dmem_we)); // R10

endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

  localparam int IMEM_N = 2048;
  localparam int DMEM_N = 64;
  localparam int LIMIT  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc, fetch_word, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  always #2.5 clk = ~clk;

  sc_core uut (
    .clk        (clk),
    .rst        (rst),
    .fetch_pc   (fetch_pc),
    .fetch_word (fetch_word),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata)
  );

  logic [31:0] imem   [IMEM_N];
  logic [31:0] dmem   [DMEM_N];
  logic [31:0] dm_ref [DMEM_N];
  logic [31:0] rf_m   [32];
  logic [31:0] pc_m;
  string       pc_tag;
  int          n_checks = 0;
  int          n_errors = 0;
  int          n;

  assign fetch_word = imem[fetch_pc[12:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(input int idx);
    return {6'b000010, 26'(idx)};
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[n] = w;
    n++;
  endtask

  // Reference step, executed before the rising edge that retires the instruction.
  task automatic step();
    logic [31:0] iw, a, b, sx, nxt, res, ea;
    logic [5:0]  op, fn;
    int          rs, rt, rd, wa;
    logic        ewe, wr;
    string       tag;
    iw  = imem[pc_m[12:2]];
    op  = iw[31:26];
    fn  = iw[5:0];
    rs  = int'(iw[25:21]);
    rt  = int'(iw[20:16]);
    rd  = int'(iw[15:11]);
    a   = rf_m[rs];
    b   = rf_m[rt];
    sx  = {{16{iw[15]}}, iw[15:0]};
    ea  = a + sx;
    nxt = pc_m + 32'd4;
    ewe = 1'b0; wr = 1'b0; wa = 0; res = '0; tag = "R10";
    case (op)
      6'b000000: begin
        wr = 1'b1; wa = rd; tag = "R3";
        case (fn)
          6'b100000: res = a + b;
          6'b100010: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin wr = 1'b0; tag = "R10"; end
        endcase
      end
      6'b001000: begin res = ea; wr = 1'b1; wa = rt; tag = "R4"; end
      6'b100011: begin res = dm_ref[ea[7:2]]; wr = 1'b1; wa = rt; tag = "R5"; end
      6'b101011: begin ewe = 1'b1; tag = (rt == 0) ? "R9" : "R6"; end
      6'b000100: begin tag = "R7"; if (a == b) nxt = pc_m + 32'd4 + (sx << 2); end
      6'b000101: begin tag = "R7"; if (a != b) nxt = pc_m + 32'd4 + (sx << 2); end
      6'b000010: begin tag = "R8"; nxt = {nxt[31:28], iw[25:0], 2'b00}; end
      default: tag = "R10";
    endcase
    chk(pc_tag, "pc", fetch_pc, pc_m);
    chk(tag, "store strobe", {31'b0, dmem_we}, {31'b0, ewe});
    if (ewe) begin
      chk(tag, "store addr", dmem_addr, ea);
      chk(tag, "store data", dmem_wdata, b);
      dm_ref[ea[7:2]] = b;
    end
    if (op == 6'b100011) chk("R5", "load addr", dmem_addr, ea);
    if (wr && wa != 0) rf_m[wa] = res;   // R9: writes to register 0 vanish
    if (op == 6'b000100 || op == 6'b000101) pc_tag = "R7";
    else if (op == 6'b000010) pc_tag = "R8";
    else pc_tag = "R2";
    pc_m = nxt;
  endtask

  initial begin
    int cyc;
    int k;
    int halt_idx;
    int loop_idx;
    int vals [10];
    logic [5:0] fns [5];
    for (int i = 0; i < IMEM_N; i++) imem[i] = 32'h0;
    for (int i = 0; i < DMEM_N; i++) begin dmem[i] = '0; dm_ref[i] = '0; end
    for (int i = 0; i < 32; i++) rf_m[i] = '0;
    fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
    fns[3] = 6'b100101; fns[4] = 6'b101010;
    n = 0;

    // R9: attempt to write register 0, then store it
    emit(enc_i(6'b001000, 0, 0, 5));
    emit(enc_i(6'b101011, 0, 0, 252));
    // R4: operand set, including sign-extension corners
    emit(enc_i(6'b001000, 0, 1, 1));
    emit(enc_i(6'b001000, 0, 2, -1));
    emit(enc_i(6'b001000, 0, 3, 32'h7fff));
    emit(enc_i(6'b001000, 0, 4, 32'h8000));
    emit(enc_i(6'b001000, 0, 5, 32'h1234));
    emit(enc_i(6'b001000, 0, 6, -2));
    emit(enc_i(6'b001000, 0, 7, 0));
    emit(enc_i(6'b001000, 0, 8, 1));
    for (int i = 0; i < 31; i++) emit(enc_r(6'b100000, 8, 8, 8));
    emit(enc_r(6'b100010, 9, 8, 1));
    emit(enc_i(6'b001000, 0, 21, 128));
    // R3/R6: every function over every operand pair, each result stored
    k = 0;
    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++)
        for (int f = 0; f < 5; f++) begin
          emit(enc_r(fns[f], 20, x, y));
          emit(enc_i(6'b101011, 21, 20, -4 * ((k % 32) + 1)));
          k++;
        end
    // R5: loads, including one into register 0 (R9)
    for (int i = 0; i < 8; i++) begin
      emit(enc_i(6'b100011, 21, 22, -4 * (i + 1)));
      emit(enc_r(6'b100000, 23, 22, 1));
      emit(enc_i(6'b101011, 0, 23, 4 * i));
    end
    emit(enc_i(6'b100011, 21, 0, -4));
    emit(enc_i(6'b101011, 0, 0, 248));
    // R7: taken and not-taken branches of both kinds
    emit(enc_i(6'b001000, 0, 25, 32'h55));
    emit(enc_i(6'b000100, 1, 1, 1));
    emit(enc_i(6'b001000, 0, 25, 32'h111));
    emit(enc_i(6'b000100, 1, 2, 1));
    emit(enc_i(6'b001000, 25, 25, 1));
    emit(enc_i(6'b000101, 1, 2, 1));
    emit(enc_i(6'b001000, 0, 25, 32'h222));
    emit(enc_i(6'b000101, 1, 1, 1));
    emit(enc_i(6'b001000, 25, 25, 2));
    emit(enc_i(6'b101011, 0, 25, 200));
    emit(enc_i(6'b001000, 0, 24, 3));
    loop_idx = n;
    emit(enc_i(6'b001000, 24, 24, -1));
    emit(enc_i(6'b000101, 24, 0, -2));
    emit(enc_i(6'b101011, 0, 24, 196));
    // R8: forward jump over a write
    emit(enc_j(n + 2));
    emit(enc_i(6'b001000, 0, 25, 32'h333));
    emit(enc_i(6'b101011, 0, 25, 192));
    // R10: unknown opcode and unknown function code leave r25 untouched
    emit(32'hFC19_1234);
    emit(enc_r(6'b100111, 25, 1, 2));
    emit(enc_r(6'b000000, 25, 1, 2));
    emit(enc_i(6'b101011, 0, 25, 188));
    halt_idx = n;
    emit(enc_j(halt_idx));

    // R1: reset state
    pc_m = '0;
    pc_tag = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", fetch_pc, 32'h0);
    chk("R1", "store strobe in reset", {31'b0, dmem_we}, 32'h0);
    rst = 1'b0;
    #0.5;
    step();
    cyc = 0;
    while (pc_m != 32'(halt_idx * 4) && cyc < LIMIT) begin
      @(negedge clk);
      step();
      cyc++;
    end
    if (cyc >= LIMIT) begin
      n_errors++;
      $display("FAIL watchdog expired");
    end
    repeat (2) begin @(negedge clk); step(); end
    @(negedge clk);
    for (int i = 0; i < DMEM_N; i++) chk("R6", "data memory image", dmem[i], dm_ref[i]);
    chk("R10", "r25 kept after no-ops", dmem[47], 32'h58);
    chk("R9", "register 0 stored", dmem[63], 32'h0);

    // R1: reset again in mid-run
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "pc after second reset", fetch_pc, 32'h0);
    chk("R1", "store strobe in second reset", {31'b0, dmem_we}, 32'h0);
    if (loop_idx < 0) n_errors++;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule